// File: doc/BRIEF.md
# Dual-Width Register ALU

This block is the arithmetic and logic unit of a small 16-bit processor. It takes a 5-bit opcode, the two register operands, the 4-bit second-register field (read as a small immediate by the immediate opcodes) and a width select. From these it produces a result word and a write-enable that tells the register file whether to store that result. Loads, stores and control flow are handled elsewhere, so the ALU leaves write-enable low for those opcodes.

The same opcodes run at two widths. With the width select low the whole 16-bit word is used, which is the normal mode for absolute register addressing. With it high, which the pipeline does for stack-relative instructions, the operation runs on the low 12 bits. In that mode the result wraps at 12 bits and its top four bits are forced to zero. One opcode sets the three bits just below the sign bit, so that an address can be pushed into the upper region of memory.

By default the result and write-enable pass through one register stage that clears on reset. Setting a parameter removes that stage and makes the block purely combinational.

Top module: `dw_alu`

## Requirements
- R1: With the width select low, the register-register opcodes 8 (add), 9 (subtract A minus B), 10 (and), 11 (or) and 18 (xor) produce the 16-bit result of operand A with operand B, wrapping modulo 2^16, and assert write-enable.
- R2: Opcode 16 shifts operand A right by one with a zero entering at the top bit of the active width. Opcode 17 shifts it left by one with a zero entering bit 0. Opcode 19 inverts it. All three assert write-enable and ignore operand B.
- R3: With the width select low, opcode 23 returns operand A ORed with 0x7000 and asserts write-enable.
- R4: Opcodes 24 (add), 25 (subtract), 26 (and) and 27 (or) use the 4-bit immediate input, zero-extended, in place of operand B. Operand B has no effect on their result.
- R5: Opcodes 20, 21 and 22 copy operand B to the result unchanged when the width select is low, and assert write-enable. Operand A has no effect on them.
- R6: With the width select high, every handled opcode, including the copy and bit-set opcodes, works on bits 11:0 of its operands only. The arithmetic wraps modulo 2^12 and result bits 15:12 are zero.
- R7: For opcodes 0 to 7, 12 to 15 and 28 to 31, write-enable is low and the result is zero.
- R8: With the registered output (the default), result and write-enable reflect the inputs present at the previous rising clock edge. While reset is low both read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Active-low asynchronous reset |
| opcode | input | 5 | Operation code |
| opA | input | 16 | Operand A, the first register's value |
| opB | input | 16 | Operand B, the second register's value |
| immField | input | 4 | Second-register field, used as an unsigned immediate |
| narrow | input | 1 | 1 selects 12-bit operation, 0 selects 16-bit |
| result | output | 16 | Value to write back |
| wrEn | output | 1 | Result should be written back |

## Verification
The bench targets the places where the two widths differ.

- **Narrow arithmetic:** the narrow add and subtract use operands whose upper nibble is set and sums that cross bit 11. A design that masks only the output, or masks nothing, would leak a carry or a stale high bit into bits 15:12.
- **Narrow right shift:** it starts from a word with the top bits set. A design that shifts before masking would pull a one into bit 11.
- **Immediate opcodes:** they run with all-ones on operand B. A design that selects the wrong operand, or sign-extends the immediate, returns a visibly different word.
- **Unhandled opcodes:** every one of them is swept, to catch a decoder that writes back on a load or a jump.
- **Output timing:** the registered path is checked on both sides of a clock edge, which exposes a missing or doubled stage.

// File: rtl/dw_alu_pkg.sv
package dw_alu_pkg;

  localparam int OP_W = 5;

  // opcode values seen by the decoder
  localparam logic [OP_W-1:0] OP_ADD  = 5'd8;
  localparam logic [OP_W-1:0] OP_SUB  = 5'd9;
  localparam logic [OP_W-1:0] OP_AND  = 5'd10;
  localparam logic [OP_W-1:0] OP_OR   = 5'd11;
  localparam logic [OP_W-1:0] OP_SRL  = 5'd16;
  localparam logic [OP_W-1:0] OP_SLL  = 5'd17;
  localparam logic [OP_W-1:0] OP_XOR  = 5'd18;
  localparam logic [OP_W-1:0] OP_NOT  = 5'd19;
  localparam logic [OP_W-1:0] OP_MOV  = 5'd20;
  localparam logic [OP_W-1:0] OP_MOVB = 5'd21;
  localparam logic [OP_W-1:0] OP_MOVA = 5'd22;
  localparam logic [OP_W-1:0] OP_HIGH = 5'd23;
  localparam logic [OP_W-1:0] OP_ADDI = 5'd24;
  localparam logic [OP_W-1:0] OP_SUBI = 5'd25;
  localparam logic [OP_W-1:0] OP_ANDI = 5'd26;
  localparam logic [OP_W-1:0] OP_ORI  = 5'd27;

  typedef enum logic [3:0] {
    FN_NONE,
    FN_ADD,
    FN_SUB,
    FN_AND,
    FN_OR,
    FN_XOR,
    FN_SRL,
    FN_SLL,
    FN_NOT,
    FN_PASSB,
    FN_HIGH
  } aluFn_e;

  // strobes from decode to datapath
  typedef struct packed {
    aluFn_e fn;
    logic   useImm;
    logic   writeEn;
    logic   narrow;
  } aluCtrl_t;

endpackage

// File: rtl/dw_alu_ctrl.sv
module dw_alu_ctrl
  import dw_alu_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  input  logic            narrow,
  output aluCtrl_t        ctrl
);

  aluFn_e fnSel;
  logic   immSel;

  always_comb begin
    fnSel  = FN_NONE;
    immSel = 1'b0;
    unique case (opcode)
      OP_ADD:  fnSel = FN_ADD;
      OP_SUB:  fnSel = FN_SUB;
      OP_AND:  fnSel = FN_AND;
      OP_OR:   fnSel = FN_OR;
      OP_XOR:  fnSel = FN_XOR;
      OP_SRL:  fnSel = FN_SRL;
      OP_SLL:  fnSel = FN_SLL;
      OP_NOT:  fnSel = FN_NOT;
      OP_MOV,
      OP_MOVB,
      OP_MOVA: fnSel = FN_PASSB;
      OP_HIGH: fnSel = FN_HIGH;
      OP_ADDI: begin fnSel = FN_ADD; immSel = 1'b1; end
      OP_SUBI: begin fnSel = FN_SUB; immSel = 1'b1; end
      OP_ANDI: begin fnSel = FN_AND; immSel = 1'b1; end
      OP_ORI:  begin fnSel = FN_OR;  immSel = 1'b1; end
      default: begin fnSel = FN_NONE; immSel = 1'b0; end
    endcase
  end

  always_comb begin
    ctrl.fn      = fnSel;
    ctrl.useImm  = immSel;
    ctrl.writeEn = (fnSel != FN_NONE);
    ctrl.narrow  = narrow;
  end

endmodule

// File: rtl/dw_alu_dp.sv
module dw_alu_dp
  import dw_alu_pkg::*;
#(
  parameter int              DATA_W    = 16,
  parameter int              NARROW_W  = 12,
  parameter int              IMM_W     = 4,
  parameter logic [DATA_W-1:0] HIGH_MASK = 16'h7000
) (
  input  aluCtrl_t          ctrl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [IMM_W-1:0]  immField,
  output logic [DATA_W-1:0] aluOut
);

  localparam int PAD_W = DATA_W - IMM_W;
  localparam logic [DATA_W-1:0] NARROW_MASK =
    {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [DATA_W-1:0] widthMask;
  logic [DATA_W-1:0] immExt;
  logic [DATA_W-1:0] srcA;
  logic [DATA_W-1:0] srcB;
  logic [DATA_W-1:0] rawOut;

  // operands are trimmed before the operation so narrow shifts bring in zeros
  always_comb begin
    widthMask = ctrl.narrow ? NARROW_MASK : {DATA_W{1'b1}};
    immExt    = {{PAD_W{1'b0}}, immField};
    srcA      = opA & widthMask;
    srcB      = (ctrl.useImm ? immExt : opB) & widthMask;
  end

  always_comb begin
    unique case (ctrl.fn)
      FN_ADD:   rawOut = srcA + srcB;
      FN_SUB:   rawOut = srcA - srcB;
      FN_AND:   rawOut = srcA & srcB;
      FN_OR:    rawOut = srcA | srcB;
      FN_XOR:   rawOut = srcA ^ srcB;
      FN_SRL:   rawOut = {1'b0, srcA[DATA_W-1:1]};
      FN_SLL:   rawOut = {srcA[DATA_W-2:0], 1'b0};
      FN_NOT:   rawOut = ~srcA;
      FN_PASSB: rawOut = srcB;
      FN_HIGH:  rawOut = srcA | HIGH_MASK;
      default:  rawOut = '0;
    endcase
  end

  assign aluOut = ctrl.writeEn ? (rawOut & widthMask) : '0;

endmodule

// File: rtl/dw_alu.sv
module dw_alu
  import dw_alu_pkg::*;
#(
  parameter int                DATA_W    = 16,
  parameter int                NARROW_W  = 12,
  parameter int                IMM_W     = 4,
  parameter logic [DATA_W-1:0] HIGH_MASK = 16'h7000,
  parameter bit                REG_OUT   = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [OP_W-1:0]   opcode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [IMM_W-1:0]  immField,
  input  logic              narrow,
  output logic [DATA_W-1:0] result,
  output logic              wrEn
);

  aluCtrl_t          ctrl;
  logic [DATA_W-1:0] aluOut;

  dw_alu_ctrl u_ctrl (
    .opcode (opcode),
    .narrow (narrow),
    .ctrl   (ctrl)
  );

  dw_alu_dp #(
    .DATA_W    (DATA_W),
    .NARROW_W  (NARROW_W),
    .IMM_W     (IMM_W),
    .HIGH_MASK (HIGH_MASK)
  ) u_dp (
    .ctrl     (ctrl),
    .opA      (opA),
    .opB      (opB),
    .immField (immField),
    .aluOut   (aluOut)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          result <= '0;
          wrEn   <= 1'b0;
        end else begin
          result <= aluOut;
          wrEn   <= ctrl.writeEn;
        end
      end
    end else begin : g_comb
      assign result = aluOut;
      assign wrEn   = ctrl.writeEn;
    end
  endgenerate

endmodule

// File: rtl/dw_alu_chk.sv
module dw_alu_chk
  import dw_alu_pkg::*;
#(
  parameter int                DATA_W    = 16,
  parameter int                NARROW_W  = 12,
  parameter int                IMM_W     = 4,
  parameter logic [DATA_W-1:0] HIGH_MASK = 16'h7000,
  parameter bit                REG_OUT   = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic [OP_W-1:0]   opcode,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [IMM_W-1:0]  immField,
  input logic              narrow,
  input logic [DATA_W-1:0] result,
  input logic              wrEn
);

  logic [OP_W-1:0]   dOp;
  logic [DATA_W-1:0] dA;
  logic [DATA_W-1:0] dB;
  logic [IMM_W-1:0]  dImm;
  logic              dNarrow;

  // align the inputs with the output they produced
  generate
    if (REG_OUT) begin : g_dly
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          dOp <= '0; dA <= '0; dB <= '0; dImm <= '0; dNarrow <= 1'b0;
        end else begin
          dOp <= opcode; dA <= opA; dB <= opB; dImm <= immField; dNarrow <= narrow;
        end
      end
    end else begin : g_now
      always_comb begin
        dOp = opcode; dA = opA; dB = opB; dImm = immField; dNarrow = narrow;
      end
    end
  endgenerate

  logic dHandled;
  logic [DATA_W-1:0] dImmExt;
  always_comb begin
    dHandled = (dOp >= 5'd8 && dOp <= 5'd11) || (dOp >= 5'd16 && dOp <= 5'd27);
    dImmExt  = {{(DATA_W-IMM_W){1'b0}}, dImm};
  end

  // R1
  add_wide_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dOp == OP_ADD && !dNarrow) |-> (wrEn && result == DATA_W'(dA + dB)));

  // R2
  sll_zero_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dOp == OP_SLL) |-> (wrEn && !result[0]));

  // R2
  srl_zero_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dOp == OP_SRL && !dNarrow) |-> (wrEn && !result[DATA_W-1]));

  // R3
  high_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dOp == OP_HIGH && !dNarrow) |-> ((result & HIGH_MASK) == HIGH_MASK));

  // R4
  andi_imm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dOp == OP_ANDI) |-> ((result & ~dImmExt) == '0));

  // R5
  pass_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dOp >= OP_MOV && dOp <= OP_MOVA && !dNarrow) |-> (wrEn && result == dB));

  // R6
  narrow_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    dNarrow |-> (result[DATA_W-1:NARROW_W] == '0));

  // R7
  unhandled_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dHandled |-> (!wrEn && result == '0));

endmodule

bind dw_alu dw_alu_chk #(
  .DATA_W    (DATA_W),
  .NARROW_W  (NARROW_W),
  .IMM_W     (IMM_W),
  .HIGH_MASK (HIGH_MASK),
  .REG_OUT   (REG_OUT)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .opcode   (opcode),
  .opA      (opA),
  .opB      (opB),
  .immField (immField),
  .narrow   (narrow),
  .result   (result),
  .wrEn     (wrEn)
);

// File: tb/dw_alu_test.sv
module dw_alu_test;

  localparam int PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 200000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  opcode = '0;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic [3:0]  immField = '0;
  logic        narrow = 1'b0;
  logic [15:0] result;
  logic        wrEn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  dw_alu uut (
    .clk      (clk),
    .rstN     (rstN),
    .opcode   (opcode),
    .opA      (opA),
    .opB      (opB),
    .immField (immField),
    .narrow   (narrow),
    .result   (result),
    .wrEn     (wrEn)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [15:0] expRes, logic expWe);
    checks++;
    if (result !== expRes || wrEn !== expWe) begin
      errors++;
      $display("FAIL %s: result=%h wrEn=%b expected result=%h wrEn=%b",
               req, result, wrEn, expRes, expWe);
    end
  endtask

  // drive at a falling edge, let one rising edge register it, check at the next fall
  task automatic run(string req, logic [4:0] op, logic [15:0] a, logic [15:0] b,
                     logic [3:0] imm, logic nar, logic [15:0] expRes, logic expWe);
    @(negedge clk);
    opcode = op; opA = a; opB = b; immField = imm; narrow = nar;
    @(posedge clk);
    @(negedge clk);
    check(req, expRes, expWe);
  endtask

  task automatic test_reset();
    opcode = 5'd8; opA = 16'h1111; opB = 16'h2222; narrow = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 reset", 16'h0000, 1'b0);
    rstN = 1'b1;
  endtask

  task automatic test_reg_reg();
    run("R1 add", 5'd8, 16'h1234, 16'h0F0F, 4'h0, 1'b0, 16'h2143, 1'b1);
    run("R1 add wrap", 5'd8, 16'hFFFF, 16'h0002, 4'h0, 1'b0, 16'h0001, 1'b1);
    run("R1 sub", 5'd9, 16'h0005, 16'h0007, 4'h0, 1'b0, 16'hFFFE, 1'b1);
    run("R1 and", 5'd10, 16'hF0F0, 16'h3C3C, 4'h0, 1'b0, 16'h3030, 1'b1);
    run("R1 or", 5'd11, 16'hF0F0, 16'h3C3C, 4'h0, 1'b0, 16'hFCFC, 1'b1);
    run("R1 xor", 5'd18, 16'hF0F0, 16'h3C3C, 4'h0, 1'b0, 16'hCCCC, 1'b1);
  endtask

  task automatic test_unary();
    run("R2 srl", 5'd16, 16'h8001, 16'hFFFF, 4'h0, 1'b0, 16'h4000, 1'b1);
    run("R2 sll", 5'd17, 16'h8001, 16'hFFFF, 4'h0, 1'b0, 16'h0002, 1'b1);
    run("R2 not", 5'd19, 16'h00FF, 16'h1234, 4'h0, 1'b0, 16'hFF00, 1'b1);
  endtask

  task automatic test_high();
    run("R3 high", 5'd23, 16'h0005, 16'h0000, 4'h0, 1'b0, 16'h7005, 1'b1);
    run("R3 high set", 5'd23, 16'hF00F, 16'h0000, 4'h0, 1'b0, 16'hF00F, 1'b1);
  endtask

  task automatic test_imm();
    run("R4 addi", 5'd24, 16'h00FF, 16'hFFFF, 4'hF, 1'b0, 16'h010E, 1'b1);
    run("R4 subi", 5'd25, 16'h0000, 16'hFFFF, 4'h1, 1'b0, 16'hFFFF, 1'b1);
    run("R4 andi", 5'd26, 16'hFFFF, 16'h0000, 4'hA, 1'b0, 16'h000A, 1'b1);
    run("R4 ori", 5'd27, 16'h1230, 16'hFFFF, 4'h5, 1'b0, 16'h1235, 1'b1);
  endtask

  task automatic test_mov();
    run("R5 mov", 5'd20, 16'h1111, 16'hBEEF, 4'h3, 1'b0, 16'hBEEF, 1'b1);
    run("R5 movb", 5'd21, 16'h2222, 16'hBEEF, 4'h3, 1'b0, 16'hBEEF, 1'b1);
    run("R5 mova", 5'd22, 16'h3333, 16'hBEEF, 4'h3, 1'b0, 16'hBEEF, 1'b1);
  endtask

  task automatic test_narrow();
    run("R6 add wrap", 5'd8, 16'h0FFF, 16'h0001, 4'h0, 1'b1, 16'h0000, 1'b1);
    run("R6 add upper", 5'd8, 16'hF800, 16'h0801, 4'h0, 1'b1, 16'h0001, 1'b1);
    run("R6 subi", 5'd25, 16'h0000, 16'h0000, 4'h1, 1'b1, 16'h0FFF, 1'b1);
    run("R6 srl", 5'd16, 16'hF002, 16'h0000, 4'h0, 1'b1, 16'h0001, 1'b1);
    run("R6 sll", 5'd17, 16'h0801, 16'h0000, 4'h0, 1'b1, 16'h0002, 1'b1);
    run("R6 not", 5'd19, 16'h0000, 16'h0000, 4'h0, 1'b1, 16'h0FFF, 1'b1);
    run("R6 mov", 5'd20, 16'h0000, 16'hBEEF, 4'h0, 1'b1, 16'h0EEF, 1'b1);
    run("R6 high", 5'd23, 16'h0ABC, 16'h0000, 4'h0, 1'b1, 16'h0ABC, 1'b1);
  endtask

  task automatic test_unhandled();
    for (int op = 0; op < 32; op++) begin
      if (!((op >= 8 && op <= 11) || (op >= 16 && op <= 27)))
        run("R7 unhandled", 5'(op), 16'hA5A5, 16'h5A5A, 4'hF, 1'b0, 16'h0000, 1'b0);
    end
  endtask

  task automatic test_latency();
    run("R8 prior", 5'd11, 16'h0F00, 16'h00F0, 4'h0, 1'b0, 16'h0FF0, 1'b1);
    @(negedge clk);
    opcode = 5'd9; opA = 16'h0010; opB = 16'h0001; narrow = 1'b0;
    #1;
    check("R8 held before edge", 16'h0FF0, 1'b1);
    @(posedge clk);
    @(negedge clk);
    check("R8 after edge", 16'h000F, 1'b1);
  endtask

  initial begin
    test_reset();
    test_reg_reg();
    test_unary();
    test_high();
    test_imm();
    test_mov();
    test_narrow();
    test_unhandled();
    test_latency();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule